// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block is the top-level state keeper of a DRAM memory controller. Software changes the controller's operating state by issuing a 3-bit state-control command. The block reports where it is on a 3-bit status output.

A move between stable states always goes through a request state. The block waits in that request state until the PHY or memory side returns a completion acknowledge. A command that is not allowed in the present state does nothing, except that it raises a sticky error flag.

Two further functions sit beside the state machine:
- A power-up sequencer. A start pulse launches a fixed-length sequence, and a done bit reports its end. Software waits for that bit before sending memory commands.
- Hardware-initiated low-power entry. When it is enabled, an idle indication from the memory side can take the controller from access into low power without any software command.

Top module: `dram_opstate_ctrl`

## Requirements
- R1: After reset, status reads 0 (init-memory), the error flag is 0 and the power-up done bit is 0. Reset also clears a previously set error flag.
- R2: Status encodes 0 init-memory, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. Command codes are 0 init, 1 config, 2 go, 3 sleep, 4 wakeup; codes 5 to 7 are undefined.
- R3: A config command (code 1) taken in init-memory or in access moves status to config-request at the next clock edge, and then to config on acknowledge.
- R4: A go command (code 2) taken in config moves status to access-request, and then to access on acknowledge.
- R5: A sleep command (code 3) is legal only in access. It passes through low-power-entry-request to low-power. A wakeup command (code 4) in low-power passes through low-power-exit-request to access. Config is not legal in low-power.
- R6: A request state lasts at least one cycle. It stays unchanged while the acknowledge input is low, and advances at the first clock edge at which the acknowledge is high. An acknowledge seen in a stable state has no effect.
- R7: A command that is illegal in the present state leaves the status unchanged and sets the error flag. Illegal commands include any command during a request state, the init command, and codes 5 to 7. The error flag stays set until reset.
- R8: In access, with the hardware low-power enable high, an idle request with no command present moves status to low-power-entry-request. With the enable low, the idle request has no effect. A command present in the same cycle takes priority over the idle request.
- R9: A power-up start pulse, while no sequence is running and done is still 0, sets the done bit exactly PWRUP_CYCLES clock edges after the edge that sampled the start. The done bit then stays set, and further start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A state-control command is present this cycle |
| cmd_code | input | 3 | State-control command code |
| phy_ack | input | 1 | Completion acknowledge from the PHY or memory side |
| hw_lp_en | input | 1 | Allows hardware-initiated low-power entry |
| hw_idle_req | input | 1 | Idle indication requesting low-power entry |
| pwrup_start | input | 1 | Starts the power-up sequence |
| pwrup_done | output | 1 | Power-up sequence has completed (sticky) |
| state_o | output | 3 | Current operating state code |
| cmd_err | output | 1 | Sticky illegal-command flag |

## Verification
Every legal command is applied in each state where it is legal. Every state is also given commands that are illegal there, including the undefined codes. This separates a wrong transition table from a flag that is merely mis-set.

Acknowledge is held low for several cycles inside each request state, which catches a request state that advances too early. Acknowledge is also pulsed in stable states, which catches a machine that reacts to it where it should not.

Idle requests are applied with the enable low, with the enable high, and together with a command. This exposes a wrong priority between hardware and software entry.

The power-up sequence is checked on the exact cycle at which done rises. A second start pulse then shows whether a restart is wrongly accepted.

// File: rtl/dram_opstate_pkg.sv
package dram_opstate_pkg;

  typedef enum logic [2:0] {
    ST_INIT_MEM  = 3'd0,
    ST_CONFIG    = 3'd1,
    ST_CFG_REQ   = 3'd2,
    ST_ACCESS    = 3'd3,
    ST_ACC_REQ   = 3'd4,
    ST_LOW_POWER = 3'd5,
    ST_LP_IN_REQ = 3'd6,
    ST_LP_OUT_REQ= 3'd7
  } opstate_e;

  typedef enum logic [2:0] {
    CMD_INIT   = 3'd0,
    CMD_CONFIG = 3'd1,
    CMD_GO     = 3'd2,
    CMD_SLEEP  = 3'd3,
    CMD_WAKEUP = 3'd4
  } opcmd_e;

  typedef struct packed {
    logic     legal;
    opstate_e next;
  } decode_t;

  // True for the transitional states that wait on the acknowledge.
  function automatic logic is_request(opstate_e s);
    return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
           (s == ST_LP_IN_REQ) || (s == ST_LP_OUT_REQ);
  endfunction

  // Stable state that a request state settles into.
  function automatic opstate_e request_target(opstate_e s);
    opstate_e t;
    unique case (s)
      ST_CFG_REQ:    t = ST_CONFIG;
      ST_ACC_REQ:    t = ST_ACCESS;
      ST_LP_IN_REQ:  t = ST_LOW_POWER;
      ST_LP_OUT_REQ: t = ST_ACCESS;
      default:       t = s;
    endcase
    return t;
  endfunction

  // Legality and destination of a software command in a given state.
  function automatic decode_t decode_cmd(opstate_e s, logic [2:0] code);
    decode_t d;
    d.legal = 1'b0;
    d.next  = s;
    if (code == CMD_CONFIG && (s == ST_INIT_MEM || s == ST_ACCESS)) begin
      d.legal = 1'b1; d.next = ST_CFG_REQ;
    end else if (code == CMD_GO && s == ST_CONFIG) begin
      d.legal = 1'b1; d.next = ST_ACC_REQ;
    end else if (code == CMD_SLEEP && s == ST_ACCESS) begin
      d.legal = 1'b1; d.next = ST_LP_IN_REQ;
    end else if (code == CMD_WAKEUP && s == ST_LOW_POWER) begin
      d.legal = 1'b1; d.next = ST_LP_OUT_REQ;
    end
    return d;
  endfunction

endpackage

// File: rtl/dram_opstate_fsm.sv
module dram_opstate_fsm
  import dram_opstate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       phy_ack,
  input  logic       hw_lp_en,
  input  logic       hw_idle_req,
  output opstate_e   state_o,
  output logic       illegal_o
);

  opstate_e state_q, state_d;
  decode_t  dec;
  logic     in_req;
  logic     hw_lp_go;
  logic     illegal_evt;

  assign in_req      = is_request(state_q);
  assign dec         = decode_cmd(state_q, cmd_code);
  assign illegal_evt = cmd_valid && !dec.legal;
  assign hw_lp_go    = hw_lp_en && hw_idle_req && !cmd_valid &&
                       (state_q == ST_ACCESS);

  always_comb begin
    state_d = state_q;
    if (in_req) begin
      if (phy_ack) state_d = request_target(state_q);
    end else if (cmd_valid) begin
      if (dec.legal) state_d = dec.next;
    end else if (hw_lp_go) begin
      state_d = ST_LP_IN_REQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT_MEM;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign illegal_o = illegal_evt;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !phy_ack) |=> $stable(state_q));

  assert_illegal_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_evt && !in_req) |=> $stable(state_q));

  assert_config_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONFIG && !$stable(state_q)) |-> $past(state_q) == ST_CFG_REQ);

  assert_access_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCESS && !$stable(state_q)) |->
      ($past(state_q) == ST_ACC_REQ || $past(state_q) == ST_LP_OUT_REQ));

  assert_lp_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOW_POWER && !$stable(state_q)) |-> $past(state_q) == ST_LP_IN_REQ);

  assert_hw_lp_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCESS && !cmd_valid && !hw_lp_en) |=> state_q == ST_ACCESS);

endmodule

// File: rtl/dram_opstate_pwrup.sv
module dram_opstate_pwrup #(
  parameter int unsigned PWRUP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(PWRUP_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic          start_evt;
  logic          last_evt;

  assign start_evt = start_i && !busy_q && !done_q;
  assign last_evt  = busy_q && (cnt_q == CW'(PWRUP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_evt) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (last_evt) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(PWRUP_CYCLES)));

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

endmodule

// File: rtl/dram_opstate_errflag.sv
module dram_opstate_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);

  assert_err_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_i));

endmodule

// File: rtl/dram_opstate_ctrl.sv
module dram_opstate_ctrl
  import dram_opstate_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       phy_ack,
  input  logic       hw_lp_en,
  input  logic       hw_idle_req,
  input  logic       pwrup_start,
  output logic       pwrup_done,
  output logic [2:0] state_o,
  output logic       cmd_err
);

  opstate_e state_w;
  logic     illegal_w;

  dram_opstate_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .phy_ack     (phy_ack),
    .hw_lp_en    (hw_lp_en),
    .hw_idle_req (hw_idle_req),
    .state_o     (state_w),
    .illegal_o   (illegal_w)
  );

  dram_opstate_errflag u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (illegal_w),
    .flag_o (cmd_err)
  );

  dram_opstate_pwrup #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (pwrup_start),
    .done_o  (pwrup_done)
  );

  assign state_o = state_w;

endmodule

// File: tb/dram_opstate_ctrl_tb_top.sv
module dram_opstate_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PWR_N      = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       phy_ack = 1'b0;
  logic       hw_lp_en = 1'b0;
  logic       hw_idle_req = 1'b0;
  logic       pwrup_start = 1'b0;
  logic       pwrup_done;
  logic [2:0] state_o;
  logic       cmd_err;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_st   = 0;
  bit m_err  = 0;
  bit m_done = 0;
  int m_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_opstate_ctrl #(.PWRUP_CYCLES(PWR_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .phy_ack(phy_ack), .hw_lp_en(hw_lp_en), .hw_idle_req(hw_idle_req),
    .pwrup_start(pwrup_start), .pwrup_done(pwrup_done),
    .state_o(state_o), .cmd_err(cmd_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_err = 0; m_done = 0; m_left = 0;
    end else begin
      // power-up sequence
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) m_done = 1;
      end else if (pwrup_start && !m_done) begin
        m_left = PWR_N;
      end
      // operating state
      if (m_st == 2 || m_st == 4 || m_st == 6 || m_st == 7) begin
        if (cmd_valid) m_err = 1;
        if (phy_ack) m_st = (m_st == 2) ? 1 : (m_st == 6) ? 5 : 3;
      end else if (cmd_valid) begin
        if      (cmd_code == 1 && (m_st == 0 || m_st == 3)) m_st = 2;
        else if (cmd_code == 2 && m_st == 1)                m_st = 4;
        else if (cmd_code == 3 && m_st == 3)                m_st = 6;
        else if (cmd_code == 4 && m_st == 5)                m_st = 7;
        else m_err = 1;
      end else if (m_st == 3 && hw_lp_en && hw_idle_req) begin
        m_st = 6;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Apply inputs for one cycle, then compare against the model away from the edge.
  task automatic step(bit v = 0, int code = 0, bit ack = 0, bit idle = 0, bit ps = 0);
    cmd_valid   = v;
    cmd_code    = 3'(code);
    phy_ack     = ack;
    hw_idle_req = idle;
    pwrup_start = ps;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; phy_ack = 0; hw_idle_req = 0; pwrup_start = 0;
    check(cur_req, state_o, m_st, "state");
    check(cur_req, cmd_err, m_err, "error flag");
    check(cur_req, pwrup_done, m_done, "power-up done");
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    cur_req = "R1";
    check("R1", state_o, 0, "reset state");
    check("R1", cmd_err, 0, "reset error");
    check("R1", pwrup_done, 0, "reset done");

    // R6: acknowledge in a stable state is ignored
    cur_req = "R6";
    step(0, 0, 1);
    check("R6", state_o, 0, "ack in init-memory");

    // R3: config from init-memory, request held without ack
    cur_req = "R3";
    step(1, 1);
    check("R3", state_o, 2, "config-request from init");
    cur_req = "R6";
    for (int i = 0; i < 4; i++) step();
    check("R6", state_o, 2, "request held without ack");
    step(0, 0, 1);
    check("R3", state_o, 1, "config reached on ack");

    // R4: go in config
    cur_req = "R4";
    step(1, 2);
    check("R4", state_o, 4, "access-request");
    step(); step(0, 0, 1);
    check("R4", state_o, 3, "access reached");

    // R3: config again from access, then back to access
    cur_req = "R3";
    step(1, 1);
    check("R3", state_o, 2, "config-request from access");
    step(0, 0, 1);
    check("R3", state_o, 1, "config from access");
    cur_req = "R4";
    step(1, 2); step(0, 0, 1);
    check("R4", state_o, 3, "access again");
    check("R2", cmd_err, 0, "no error so far");

    // R5: sleep path
    cur_req = "R5";
    step(1, 3);
    check("R5", state_o, 6, "lp entry request");
    step(0, 0, 1);
    check("R5", state_o, 5, "low-power");

    // R7: config in low-power is illegal
    cur_req = "R7";
    step(1, 1);
    check("R7", state_o, 5, "config rejected in low-power");
    check("R7", cmd_err, 1, "error set");

    // R5: wakeup path
    cur_req = "R5";
    step(1, 4);
    check("R5", state_o, 7, "lp exit request");
    step(); step(0, 0, 1);
    check("R5", state_o, 3, "access after wakeup");

    // R7: undefined code, init, go, wakeup in access; command during a request
    cur_req = "R7";
    step(1, 6); check("R7", state_o, 3, "code 6 ignored");
    step(1, 0); check("R7", state_o, 3, "init ignored");
    step(1, 2); check("R7", state_o, 3, "go ignored in access");
    step(1, 4); check("R7", state_o, 3, "wakeup ignored in access");
    step(1, 1);
    step(1, 2); check("R7", state_o, 2, "command in request ignored");
    step(0, 0, 1);
    step(1, 3); check("R7", state_o, 1, "sleep ignored in config");
    step(1, 7); check("R7", state_o, 1, "code 7 ignored");
    step(1, 2); step(0, 0, 1);
    check("R7", cmd_err, 1, "error still sticky");

    // R8: hardware low-power entry
    cur_req = "R8";
    hw_lp_en = 0;
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    check("R8", state_o, 3, "idle ignored when disabled");
    hw_lp_en = 1;
    step(1, 1, 0, 1);
    check("R8", state_o, 2, "command beats idle request");
    step(0, 0, 1); step(1, 2); step(0, 0, 1);
    step(0, 0, 0, 1);
    check("R8", state_o, 6, "hardware entry request");
    step(0, 0, 1);
    check("R8", state_o, 5, "hardware low-power");
    step(1, 4); step(0, 0, 1);
    check("R8", state_o, 3, "back to access");
    hw_lp_en = 0;

    // R9: power-up sequence
    cur_req = "R9";
    step(0, 0, 0, 0, 1);
    for (int i = 1; i < PWR_N; i++) begin
      if (i == 2) step(0, 0, 0, 0, 1); else step();
    end
    check("R9", pwrup_done, 0, "done not yet");
    step();
    check("R9", pwrup_done, 1, "done on exact cycle");
    step(0, 0, 0, 0, 1); step();
    check("R9", pwrup_done, 1, "done stays set");

    // R1: reset clears error
    do_reset();
    cur_req = "R1";
    check("R1", cmd_err, 0, "error cleared by reset");
    check("R1", state_o, 0, "state back to init");
    check("R1", pwrup_done, 0, "done cleared by reset");
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule